// File: doc/BRIEF.md
# Minifloat to Fixed-Point Converter

This block turns a compact 13-bit floating-point word into a signed fixed-point number. The output is wide enough to hold every value the word can encode, with no loss. The word carries a sign bit, a 4-bit biased exponent and an 8-bit fraction that has an implied leading one. None of its bit patterns is reserved, so every pattern decodes as an ordinary normalized number. There is no zero, no infinity and no NaN.

A producer presents a word together with a valid strobe. One clock later the converted value comes out with its own valid strobe and two flags. One flag marks the largest magnitude the format can hold and the other marks the smallest. When the input strobe is low, the registered outputs hold their previous contents.

Top module: `mf2fx_top`

## Requirements
- R1: The input word is split by position: bit 12 is the sign S, bits 11:8 are the exponent field E, and bits 7:0 are the fraction field M. The encoded value is (-1)^S × (1 + M/256) × 2^(E-8).
- R2: The exponent is excess-8. Field value 0 scales by 2^-8 and field value 15 scales by 2^7, with every step in between one power of two.
- R3: out_fix is a 25-bit two's-complement number with 16 fractional bits. Its integer value equals the encoded value × 2^16 exactly, for every input pattern.
- R4: With S=1, out_fix is the exact two's-complement negation of the result for the same E and M with S=0. Bit 24 of out_fix therefore equals S.
- R5: out_valid is high in the cycle after a rising clock edge at which in_valid was high, and low after an edge at which in_valid was low. The converted data and flags for a word appear at that same edge.
- R6: At an edge where in_valid is low, out_fix, out_max and out_min keep their previous values, whatever in_word holds.
- R7: out_max is high for a converted word with E=15 and M=255, for either sign, and low for every other word. That word is ±255.5, which is out_fix = ±16744448.
- R8: out_min is high for a converted word with E=0 and M=0, for either sign, and low for every other word. That word is ±2^-8, which is out_fix = ±256.
- R9: While rst is high, out_valid, out_fix, out_max and out_min are all zero. rst acts asynchronously.
- R10: The word S=0, E=0110, M=10100000 (0x06A0) converts to 0.40625, which is out_fix = 26624.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| in_valid | input | 1 | Input word is present |
| in_word | input | 13 | Sign, biased exponent and fraction |
| out_valid | output | 1 | Output data is fresh this cycle |
| out_fix | output | 25 | Signed fixed-point value, 16 fractional bits |
| out_max | output | 1 | Converted word has the largest magnitude |
| out_min | output | 1 | Converted word has the smallest magnitude |

## Verification
Every result of this block arrives one rising edge after the word is presented: the fixed-point value, both flags and the valid strobe. The bench drives each word on a falling edge. It compares the outputs at the next falling edge, which is exactly one register stage later. Hold cycles are checked at that same point: the expected value stays at the last word accepted, even while in_word changes. The reset values are checked while rst is still high, before any word is accepted.

// File: rtl/mf2fx_pkg.sv
package mf2fx_pkg;
   localparam int DEF_EXP_W  = 4;
   localparam int DEF_FRAC_W = 8;
   localparam int DEF_BIAS   = 8;

   // width of the unsigned magnitude after the widest shift
   function automatic int mag_width(input int exp_w, input int frac_w);
      return frac_w + 1 + (2 ** exp_w) - 1;
   endfunction

   typedef enum logic { SHIFT_LOG = 1'b0, SHIFT_DIRECT = 1'b1 } shift_style_e;
endpackage

// File: rtl/mf2fx_unpack.sv
module mf2fx_unpack #(
   parameter int EXP_W  = 4,
   parameter int FRAC_W = 8,
   localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
   input  logic [WORD_W-1:0]  word,
   output logic               sign,
   output logic [EXP_W-1:0]   expo,
   output logic [FRAC_W:0]    signif,
   output logic               is_max,
   output logic               is_min
);
   assign sign   = word[WORD_W-1];
   assign expo   = word[WORD_W-2 -: EXP_W];
   assign signif = {1'b1, word[FRAC_W-1:0]};
   assign is_max = (&expo) && (&word[FRAC_W-1:0]);
   assign is_min = (expo == '0) && (word[FRAC_W-1:0] == '0);
endmodule

// File: rtl/mf2fx_shift.sv
module mf2fx_shift
   import mf2fx_pkg::*;
#(
   parameter int           EXP_W  = 4,
   parameter int           FRAC_W = 8,
   parameter shift_style_e STYLE  = SHIFT_LOG,
   localparam int SIG_W = FRAC_W + 1,
   localparam int MAG_W = mag_width(EXP_W, FRAC_W)
) (
   input  logic [SIG_W-1:0] signif,
   input  logic [EXP_W-1:0] amount,
   output logic [MAG_W-1:0] mag
);
   logic [MAG_W-1:0] base;
   assign base = {{(MAG_W-SIG_W){1'b0}}, signif};

   generate
      if (STYLE == SHIFT_LOG) begin : g_log
         logic [MAG_W-1:0] stg [0:EXP_W];
         assign stg[0] = base;
         for (genvar i = 0; i < EXP_W; i++) begin : g_stage
            assign stg[i+1] = amount[i] ? (stg[i] << (1 << i)) : stg[i];
         end
         assign mag = stg[EXP_W];
      end else begin : g_direct
         assign mag = base << amount;
      end
   endgenerate
endmodule

// File: rtl/mf2fx_sign.sv
module mf2fx_sign #(
   parameter int MAG_W = 24,
   localparam int OUT_W = MAG_W + 1
) (
   input  logic             neg,
   input  logic [MAG_W-1:0] mag,
   output logic [OUT_W-1:0] fix
);
   logic [OUT_W-1:0] ext;
   assign ext = {1'b0, mag};
   assign fix = neg ? (~ext + OUT_W'(1)) : ext;
endmodule

// File: rtl/mf2fx_top.sv
module mf2fx_top
   import mf2fx_pkg::*;
#(
   parameter int           EXP_W  = DEF_EXP_W,
   parameter int           FRAC_W = DEF_FRAC_W,
   parameter int           BIAS   = DEF_BIAS,
   parameter shift_style_e STYLE  = SHIFT_LOG,
   localparam int WORD_W    = 1 + EXP_W + FRAC_W,
   localparam int MAG_W     = mag_width(EXP_W, FRAC_W),
   localparam int OUT_W     = MAG_W + 1,
   localparam int FIX_FRAC  = BIAS + FRAC_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [12:0]       in_word,
   output logic              out_valid,
   output logic [24:0]       out_fix,
   output logic              out_max,
   output logic              out_min
);
   // elaboration checks on the parameter set
   generate
      if (EXP_W < 1 || EXP_W > 5) begin : g_bad_exp
         $error("EXP_W out of supported range");
      end
      if (FRAC_W < 1) begin : g_bad_frac
         $error("FRAC_W must be positive");
      end
      if (BIAS < 0 || BIAS > (2 ** EXP_W) - 1) begin : g_bad_bias
         $error("BIAS must lie within the exponent field range");
      end
      if (WORD_W != 13 || OUT_W != 25 || FIX_FRAC != 16) begin : g_bad_ports
         $error("parameters do not match the port widths");
      end
   endgenerate

   logic               f_sign;
   logic [EXP_W-1:0]   f_exp;
   logic [FRAC_W:0]    f_sig;
   logic               f_max;
   logic               f_min;
   logic [MAG_W-1:0]   f_mag;
   logic [OUT_W-1:0]   f_fix;

   mf2fx_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
      .word   (in_word),
      .sign   (f_sign),
      .expo   (f_exp),
      .signif (f_sig),
      .is_max (f_max),
      .is_min (f_min)
   );

   mf2fx_shift #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .STYLE(STYLE)) u_shift (
      .signif (f_sig),
      .amount (f_exp),
      .mag    (f_mag)
   );

   mf2fx_sign #(.MAG_W(MAG_W)) u_sign (
      .neg (f_sign),
      .mag (f_mag),
      .fix (f_fix)
   );

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_fix   <= '0;
         out_max   <= 1'b0;
         out_min   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_fix <= f_fix;
            out_max <= f_max;
            out_min <= f_min;
         end
      end
   end

   AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);                                         // R5
   AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);                                       // R5
   AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(out_fix) && $stable(out_max) && $stable(out_min))); // R6
   AST_SIGN_BIT: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (out_fix[OUT_W-1] == $past(in_word[WORD_W-1])));    // R4
   AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_fix != '0));                                  // R3
   AST_FLAGS_APART: assert property (@(posedge clk) disable iff (rst)
      !(out_max && out_min));                                          // R7
   AST_MIN_VALUE: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_min) |-> (out_fix == 25'd256 || out_fix == -25'sd256)); // R8
endmodule

// File: tb/mf2fx_top_test.sv
module mf2fx_top_test;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [12:0] in_word = '0;
   logic        out_valid;
   logic [24:0] out_fix;
   logic        out_max;
   logic        out_min;

   int n_checks = 0;
   int n_fail   = 0;
   logic [24:0] exp_fix = '0;
   logic        exp_max = 1'b0;
   logic        exp_min = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mf2fx_top uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
      .out_valid(out_valid), .out_fix(out_fix), .out_max(out_max), .out_min(out_min)
   );

   // expected value from the number formula, computed in real arithmetic
   function automatic logic [24:0] ref_fix(input logic [12:0] w);
      real v;
      int  e;
      v = 1.0 + real'(w[7:0]) / 256.0;
      e = int'(w[11:8]) - 8;
      v = v * (2.0 ** e) * 65536.0;
      if (w[12]) v = -v;
      return 25'($rtoi(v));
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
      n_checks++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic apply(input logic [12:0] w, input logic v, input string req);
      @(negedge clk);
      in_word  = w;
      in_valid = v;
      if (v) begin
         exp_fix = ref_fix(w);
         exp_max = (w[11:0] == 12'hFFF);
         exp_min = (w[11:0] == 12'h000);
      end
      @(negedge clk);
      check({req, " valid"}, 32'(out_valid), 32'(v));
      check({req, " fix"}, 32'(signed'(out_fix)), 32'(signed'(exp_fix)));
      check({req, " max"}, 32'(out_max), 32'(exp_max));
      check({req, " min"}, 32'(out_min), 32'(exp_min));
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 valid", 32'(out_valid), 0);
      check("R9 fix", 32'(out_fix), 0);
      check("R9 max", 32'(out_max), 0);
      check("R9 min", 32'(out_min), 0);
      rst = 1'b0;

      apply(13'h06A0, 1'b1, "R10");
      check("R10 value", 32'(out_fix), 32'd26624);
      apply(13'h0FFF, 1'b1, "R7 pos");
      check("R7 value", 32'(out_fix), 32'd16744448);
      apply(13'h1FFF, 1'b1, "R7 neg");
      check("R4 neg max", 32'(signed'(out_fix)), -32'sd16744448);
      apply(13'h0000, 1'b1, "R8 pos");
      check("R2 low exp", 32'(out_fix), 32'd256);
      apply(13'h1000, 1'b1, "R8 neg");
      apply(13'h0F00, 1'b1, "R2 high exp");
      check("R2 top scale", 32'(out_fix), 32'd8388608);
      apply(13'h08FF, 1'b1, "R1 unit exp");
      apply(13'h0EFF, 1'b1, "R7 near max");
      apply(13'h0001, 1'b1, "R8 near min");
      // R6 hold: words change while in_valid is low
      apply(13'h1234, 1'b0, "R6 hold a");
      apply(13'h0FFF, 1'b0, "R6 hold b");
      apply(13'h0000, 1'b0, "R6 hold c");
      apply(13'h1555, 1'b1, "R5 resume");

      for (int k = 0; k < 300; k++) begin
         logic [12:0] w;
         logic        v;
         w = 13'($urandom);
         v = ($urandom % 4) != 0;
         apply(w, v, v ? "R3 random" : "R6 random");
         if (v) check("R4 sign bit", 32'(out_fix[24]), 32'(w[12]));
      end

      // R9 asynchronous reset mid-stream
      @(negedge clk);
      in_valid = 1'b1;
      in_word  = 13'h0ABC;
      @(posedge clk);
      #1 rst = 1'b1;
      #1;
      check("R9 async valid", 32'(out_valid), 0);
      check("R9 async fix", 32'(out_fix), 0);
      in_valid = 1'b0;
      @(negedge clk);
      rst = 1'b0;

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule